// File: doc/BRIEF.md
# Multiframe-Aligned SYSREF Source and LMFC Tracker

This block lives in the link clock domain of a subclass 1 receiver. It generates a periodic SYSREF pulse whose period is one multiframe. The multiframe length in link cycles is computed from the octets-per-frame and frames-per-multiframe settings as (F × K) / 4, because four octets move per link clock. The pulse repeats continuously, or it is issued once for each assertion of the enable. With F=2 and K=32 on a 122.88 MHz link clock the period is 16 cycles, or 7.68 MHz.

A returned SYSREF (normally the generated pulse, looped back through the board) is registered once and then edge-detected. The first rising edge restarts a local multiframe counter, so that its boundary lines up with the pulse. In single-shot detection mode, later edges leave the counter alone and only set a sticky "more than one edge" flag. In continuous mode, every later edge is checked against the counter. An edge that lands on a boundary changes nothing. An edge that lands off a boundary realigns the counter and sets a sticky misalignment flag. A small read port returns the status bits.

Top module: `sysref_lmfc_gen`

## Requirements
- R1: While rstN is low, sysrefOut is 0, lmfcCount is 0, rdData is 0, and all status bits are cleared.
- R2: With contMode=1, sysrefOut rises at the first clock edge at which enable is sampled high. It then rises again every (octetsPerFrame × framesPerMf) / 4 cycles.
- R3: Each pulse stays high for pulseWidthCfg cycles. A pulseWidthCfg of 0 selects the default width of 2 cycles.
- R4: With contMode=0, exactly one pulse is issued per enable assertion. Deasserting enable re-arms the generator.
- R5: While enable is low, sysrefOut is held at 0 from the next clock edge.
- R6: lmfcCount counts 0, 1, … up to length−1 and then wraps to 0. lmfcBoundary is high exactly when lmfcCount is 0.
- R7: If sysrefIn is first sampled high at clock edge n, lmfcCount reads 0 after edge n+1 and sets status bit 0 (captured), whatever the count would otherwise have been.
- R8: With contMode=0, any rising edge of sysrefIn after the first leaves lmfcCount unchanged and sets status bit 1 (multiple edges).
- R9: With contMode=1, a later edge whose detection cycle sees lmfcCount = length−1 is aligned: it sets bit 1 only. Any other later edge forces lmfcCount to 0 one cycle later and also sets status bit 2 (misaligned).
- R10: rdData, one cycle after rdAddr is presented, holds the zero-extended status when rdAddr equals STATUS_ADDR (default 0x10), and 0 for any other address.
- R11: The status bits are sticky. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the SYSREF generator |
| contMode | input | 1 | 1 = continuous, 0 = single-shot (generation and detection) |
| octetsPerFrame | input | F_W | F setting |
| framesPerMf | input | K_W | K setting |
| pulseWidthCfg | input | PW_W | Pulse high time in cycles; 0 selects the default |
| sysrefIn | input | 1 | Returned SYSREF to be detected |
| sysrefOut | output | 1 | Generated SYSREF pulse |
| lmfcBoundary | output | 1 | Multiframe boundary strobe |
| lmfcCount | output | F_W+K_W-2 | Local multiframe counter |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is an off-boundary edge that arrives after the counter has already been aligned. When the pulse is looped back, every later edge lands on a boundary by construction. The bench therefore drives sysrefIn from its own source rather than from the loopback. It times each injected edge from the cycle of the first capture, so that one edge lands on a boundary and another lands mid-multiframe. A separate loopback phase then checks that the block's own pulses stay aligned.

// File: rtl/sysref_lmfc_pkg.sv
package sysref_lmfc_pkg;
  localparam int ST_CAPTURED = 0;
  localparam int ST_MULTI    = 1;
  localparam int ST_MISALIGN = 2;
  localparam int ST_W        = 3;

  typedef struct packed {
    logic genRun;    // generator counting and allowed to pulse
    logic lmfcZero;  // force the multiframe counter to 0 next edge
  } lmfcStrobes_t;
endpackage

// File: rtl/sysref_lmfc_dp.sv
module sysref_lmfc_dp
  import sysref_lmfc_pkg::*;
#(
  parameter int F_W       = 5,
  parameter int K_W       = 6,
  parameter int PW_W      = 4,
  parameter int DEF_PULSE = 2,
  localparam int CNT_W    = F_W + K_W - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lmfcStrobes_t     strobes,
  input  logic [F_W-1:0]   octetsPerFrame,
  input  logic [K_W-1:0]   framesPerMf,
  input  logic [PW_W-1:0]  pulseWidthCfg,
  output logic             sysrefOut,
  output logic [CNT_W-1:0] lmfcCount,
  output logic             lmfcLast,
  output logic             genWrap
);
  localparam int PROD_W = F_W + K_W;

  logic [PROD_W-1:0] octetProduct;
  logic [CNT_W-1:0]  mfLen, lastIdx, pulseLen, genCnt, lmfcCnt;

  // four octets per link clock: multiframe length = F*K/4
  assign octetProduct = PROD_W'(octetsPerFrame) * PROD_W'(framesPerMf);
  assign mfLen        = CNT_W'(octetProduct >> 2);
  assign lastIdx      = mfLen - CNT_W'(1);
  assign pulseLen     = (pulseWidthCfg == '0) ? CNT_W'(DEF_PULSE) : CNT_W'(pulseWidthCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genCnt    <= '0;
      sysrefOut <= 1'b0;
    end else if (!strobes.genRun) begin
      genCnt    <= '0;
      sysrefOut <= 1'b0;
    end else begin
      genCnt    <= (genCnt >= lastIdx) ? '0 : genCnt + CNT_W'(1);
      sysrefOut <= (genCnt < pulseLen);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lmfcCnt <= '0;
    end else if (strobes.lmfcZero || lmfcCnt >= lastIdx) begin
      lmfcCnt <= '0;
    end else begin
      lmfcCnt <= lmfcCnt + CNT_W'(1);
    end
  end

  assign lmfcCount = lmfcCnt;
  assign lmfcLast  = (lmfcCnt == lastIdx);
  assign genWrap   = strobes.genRun && (genCnt >= lastIdx);
endmodule

// File: rtl/sysref_lmfc_ctl.sv
module sysref_lmfc_ctl
  import sysref_lmfc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            contMode,
  input  logic            sysrefIn,
  input  logic            lmfcLast,
  input  logic            genWrap,
  output lmfcStrobes_t    strobes,
  output logic [ST_W-1:0] status
);
  logic sysSampled, sysPrev, sysEdge;
  logic captured, multiSeen, misalign, genDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysSampled <= 1'b0;
      sysPrev    <= 1'b0;
    end else begin
      sysSampled <= sysrefIn;
      sysPrev    <= sysSampled;
    end
  end

  assign sysEdge = sysSampled & ~sysPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captured  <= 1'b0;
      multiSeen <= 1'b0;
      misalign  <= 1'b0;
    end else if (sysEdge) begin
      if (!captured) begin
        captured <= 1'b1;
      end else begin
        multiSeen <= 1'b1;
        if (contMode && !lmfcLast) misalign <= 1'b1;
      end
    end
  end

  // single-shot generation: stop after one full period until enable drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     genDone <= 1'b0;
    else if (!enable)              genDone <= 1'b0;
    else if (genWrap && !contMode) genDone <= 1'b1;
  end

  assign strobes.lmfcZero = sysEdge && (!captured || contMode);
  assign strobes.genRun   = enable && !genDone;

  always_comb begin
    status              = '0;
    status[ST_CAPTURED] = captured;
    status[ST_MULTI]    = multiSeen;
    status[ST_MISALIGN] = misalign;
  end
endmodule

// File: rtl/sysref_lmfc_gen.sv
module sysref_lmfc_gen
  import sysref_lmfc_pkg::*;
#(
  parameter int F_W       = 5,
  parameter int K_W       = 6,
  parameter int PW_W      = 4,
  parameter int DEF_PULSE = 2,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h10,
  localparam int CNT_W    = F_W + K_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              contMode,
  input  logic [F_W-1:0]    octetsPerFrame,
  input  logic [K_W-1:0]    framesPerMf,
  input  logic [PW_W-1:0]   pulseWidthCfg,
  input  logic              sysrefIn,
  output logic              sysrefOut,
  output logic              lmfcBoundary,
  output logic [CNT_W-1:0]  lmfcCount,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  lmfcStrobes_t    strobes;
  logic [ST_W-1:0] statusBits;
  logic            lmfcLast, genWrap;

  sysref_lmfc_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .contMode(contMode),
    .sysrefIn(sysrefIn), .lmfcLast(lmfcLast), .genWrap(genWrap),
    .strobes(strobes), .status(statusBits)
  );

  sysref_lmfc_dp #(
    .F_W(F_W), .K_W(K_W), .PW_W(PW_W), .DEF_PULSE(DEF_PULSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .octetsPerFrame(octetsPerFrame), .framesPerMf(framesPerMf),
    .pulseWidthCfg(pulseWidthCfg), .sysrefOut(sysrefOut),
    .lmfcCount(lmfcCount), .lmfcLast(lmfcLast), .genWrap(genWrap)
  );

  assign lmfcBoundary = (lmfcCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     rdData <= '0;
    else if (rdAddr == STATUS_ADDR) rdData <= DATA_W'(statusBits);
    else                           rdData <= '0;
  end
endmodule

// File: rtl/sysref_lmfc_chk.sv
module sysref_lmfc_chk
  import sysref_lmfc_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              sysrefOut,
  input logic [CNT_W-1:0]  lmfcCount,
  input logic              lmfcZero,
  input logic [ST_W-1:0]   status,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  assert_sys_low_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sysrefOut);

  assert_lmfc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lmfcCount != '0) |-> (lmfcCount == $past(lmfcCount) + CNT_W'(1)));

  assert_realign_R7: assert property (@(posedge clk) disable iff (!rstN)
    lmfcZero |=> (lmfcCount == '0));

  assert_rd_other_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdAddr) != STATUS_ADDR) |-> (rdData == '0));

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (($past(status) & ~status) == '0));
endmodule

bind sysref_lmfc_gen sysref_lmfc_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .sysrefOut(sysrefOut),
  .lmfcCount(lmfcCount), .lmfcZero(strobes.lmfcZero), .status(statusBits),
  .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/sysref_lmfc_gen_bench.sv
module sysref_lmfc_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int F_W = 5, K_W = 6, PW_W = 4, ADDR_W = 8, DATA_W = 32;
  localparam int CNT_W = F_W + K_W - 2;
  localparam logic [ADDR_W-1:0] ST_ADDR = 8'h10;

  logic clk = 1'b0, rstN, enable, contMode, sysrefIn, sysrefOut, lmfcBoundary;
  logic [F_W-1:0] octetsPerFrame;
  logic [K_W-1:0] framesPerMf;
  logic [PW_W-1:0] pulseWidthCfg;
  logic [CNT_W-1:0] lmfcCount;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic useLoop, injSys;

  assign sysrefIn = useLoop ? sysrefOut : injSys;

  sysref_lmfc_gen u_sysref_lmfc_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .contMode(contMode),
    .octetsPerFrame(octetsPerFrame), .framesPerMf(framesPerMf),
    .pulseWidthCfg(pulseWidthCfg), .sysrefIn(sysrefIn), .sysrefOut(sysrefOut),
    .lmfcBoundary(lmfcBoundary), .lmfcCount(lmfcCount),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum int {OBS_SYS, OBS_CNT, OBS_BND, OBS_RD} obs_e;
  typedef struct { int cyc; obs_e what; int val; string req; } exp_t;
  exp_t expQ[$];
  exp_t keepQ[$];
  int cyc = 0, nChecks = 0, nFails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: schedule an expected observation d cycles ahead
  task automatic expect_at(int d, obs_e w, int v, string r);
    exp_t e;
    e.cyc = cyc + d; e.what = w; e.val = v; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side: compare every item due at this sampling point
  always @(negedge clk) begin
    int act;
    keepQ = {};
    foreach (expQ[i]) begin
      if (expQ[i].cyc == cyc) begin
        case (expQ[i].what)
          OBS_SYS: act = int'(sysrefOut);
          OBS_CNT: act = int'(lmfcCount);
          OBS_BND: act = int'(lmfcBoundary);
          default: act = int'(rdData);
        endcase
        nChecks++;
        if (act != expQ[i].val) begin
          nFails++;
          $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                   expQ[i].req, expQ[i].what.name(), cyc, act, expQ[i].val);
        end
      end else begin
        keepQ.push_back(expQ[i]);
      end
    end
    expQ = keepQ;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; enable = 0; contMode = 1; octetsPerFrame = 2; framesPerMf = 32;
    pulseWidthCfg = 0; useLoop = 0; injSys = 0; rdAddr = ST_ADDR;
    step(1);
    // R1 reset state
    expect_at(1, OBS_SYS, 0, "R1"); expect_at(1, OBS_CNT, 0, "R1");
    expect_at(1, OBS_RD, 0, "R1");
    step(3);
    rstN = 1;
    // R6 free-running count, length 2*32/4 = 16
    expect_at(15, OBS_CNT, 15, "R6"); expect_at(15, OBS_BND, 0, "R6");
    expect_at(16, OBS_CNT, 0, "R6");  expect_at(16, OBS_BND, 1, "R6");
    expect_at(17, OBS_CNT, 1, "R6");  expect_at(17, OBS_BND, 0, "R6");
    step(20);
    // R7 first edge: natural count at +2 would be 6, forced to 0
    contMode = 0;
    injSys = 1;
    expect_at(2, OBS_CNT, 0, "R7"); expect_at(3, OBS_CNT, 1, "R7");
    expect_at(2, OBS_RD, 0, "R7");  expect_at(3, OBS_RD, 1, "R7");
    step(3); injSys = 0;
    step(27);
    // R8 single-shot: second edge 30 cycles after first, count keeps running
    injSys = 1;
    expect_at(2, OBS_CNT, 14, "R8"); expect_at(3, OBS_CNT, 15, "R8");
    expect_at(3, OBS_RD, 3, "R8");
    step(3); injSys = 0; contMode = 1;
    step(15);
    // R9 aligned edge (detected when count is 15)
    injSys = 1;
    expect_at(2, OBS_CNT, 0, "R9"); expect_at(3, OBS_CNT, 1, "R9");
    expect_at(3, OBS_RD, 3, "R9");
    step(3); injSys = 0;
    step(5);
    // R9 misaligned edge (detected when count is 7): realign and flag
    injSys = 1;
    expect_at(2, OBS_CNT, 0, "R9"); expect_at(3, OBS_CNT, 1, "R9");
    expect_at(3, OBS_RD, 7, "R9");
    step(3); injSys = 0;
    step(5);
    // R5 generator idle
    for (int k = 1; k <= 3; k++) expect_at(k, OBS_SYS, 0, "R5");
    step(4);
    // R2/R3 continuous, default width 2, period 16
    enable = 1;
    for (int k = 1; k <= 40; k++) expect_at(k, OBS_SYS, (((k-1) % 16) < 2) ? 1 : 0, "R2/R3");
    step(40);
    enable = 0;
    for (int k = 1; k <= 20; k++) expect_at(k, OBS_SYS, 0, "R5");
    step(20);
    // R3 width 5, period 4*8/4 = 8
    pulseWidthCfg = 5; octetsPerFrame = 4; framesPerMf = 8;
    enable = 1;
    for (int k = 1; k <= 30; k++) expect_at(k, OBS_SYS, (((k-1) % 8) < 5) ? 1 : 0, "R3");
    step(30);
    enable = 0;
    step(3);
    // R4 single-shot generation, width 3
    contMode = 0; pulseWidthCfg = 3;
    enable = 1;
    for (int k = 1; k <= 30; k++) expect_at(k, OBS_SYS, (k <= 3) ? 1 : 0, "R4");
    step(30);
    enable = 0;
    step(2);
    enable = 1;
    for (int k = 1; k <= 12; k++) expect_at(k, OBS_SYS, (k <= 3) ? 1 : 0, "R4");
    step(12);
    enable = 0;
    // R10 other address reads 0; R11 status still held
    rdAddr = ST_ADDR + 1;
    expect_at(1, OBS_RD, 0, "R10");
    step(2);
    rdAddr = ST_ADDR;
    expect_at(1, OBS_RD, 7, "R11");
    step(2);
    // R1 reset mid-run, R11 clears only on reset
    rstN = 0;
    expect_at(1, OBS_RD, 0, "R1"); expect_at(1, OBS_CNT, 0, "R1");
    expect_at(1, OBS_SYS, 0, "R1");
    step(2);
    rstN = 1;
    expect_at(2, OBS_RD, 0, "R11");
    step(3);
    // R9 loopback: own pulses are aligned, no misalignment flag
    octetsPerFrame = 2; framesPerMf = 32; pulseWidthCfg = 0; contMode = 1;
    useLoop = 1; enable = 1;
    expect_at(3, OBS_CNT, 0, "R7"); expect_at(3, OBS_BND, 1, "R7");
    expect_at(19, OBS_CNT, 0, "R9"); expect_at(35, OBS_CNT, 0, "R9");
    expect_at(40, OBS_RD, 3, "R9");
    step(42);
    while (expQ.size() != 0) step(1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule